// File: doc/BRIEF.md
# Mapping Command Entry Builder

This block turns one queued mapping command into a single table-write request. A command is either a device mapping, which binds a device number to a translation-table address and an event-ID width, or a collection mapping, which binds a collection number to a target. The command arrives as three 64-bit doublewords together with a kind select. The block pulls out the fields and checks them against the configured limits. It then emits the 64-bit entry, the table it belongs to and the row index, all one cycle after the command is accepted.

A target can be interpreted in one of two ways. In address mode it is a 64 KB-aligned physical address, so only the bits above bit 15 are kept. In processor-number mode it is a small processor index, and that index is checked against the processor count. If a mapping carries out-of-range fields, the block raises an error pulse, makes no write, and stays ready for the next command. If a command has its valid bit clear, it is an unmap: the block writes an all-zero entry. The surrounding queue engine performs the memory access and any multi-level table walk.

Top module: `mapcmd_builder`

## Requirements
- R1: While reset is asserted and right after it, wrReq and errFlag are 0, and wrEntry, wrId and wrTable are 0.
- R2: For a device command (cmdKind 0), the device number is cmdDw0[63:32], the width field is cmdDw1[4:0], the translation-table address is cmdDw2[51:8] and the map-valid flag is cmdDw2[63]. The write appears on the outputs in the cycle after cmdValid.
- R3: A device entry holds the valid flag in bit 0, the width field in bits 5:1 and the address in bits 49:6. All bits above 49 are zero.
- R4: For a collection command (cmdKind 1), the collection number is cmdDw2[15:0] and the valid flag is cmdDw2[63]. The target is cmdDw2[47:16] in address mode (physTargetMode 1) and cmdDw2[31:16] in processor-number mode.
- R5: A collection entry holds the valid flag in bit 0 and the target starting at bit 1. All other bits are zero.
- R6: A valid device command whose device number is above maxDevId, or whose width field is above idBitsLimit, pulses errFlag and makes no write. A value equal to its limit is accepted.
- R7: A valid collection command is rejected the same way when its collection number is above maxCollId, or when, in processor-number mode only, its target is above numProcs. In address mode the target is never checked.
- R8: A command with the valid flag clear skips validation, raises no error, and writes an all-zero entry to the row its ID selects.
- R9: If the addressed table's enable (devTableEn or collTableEn) is low, no write is requested. A valid command with out-of-range fields still pulses errFlag.
- R10: Commands may arrive on consecutive cycles, and each one yields its own result. A cycle without cmdValid yields neither wrReq nor errFlag.
- R11: wrTable is 0 for a device-table write and 1 for a collection-table write. wrId is the device number, or the collection number zero-extended.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| cmdValid | input | 1 | A command is presented this cycle |
| cmdKind | input | 1 | 0 device mapping, 1 collection mapping |
| cmdDw0 | input | 64 | First command doubleword |
| cmdDw1 | input | 64 | Second command doubleword |
| cmdDw2 | input | 64 | Third command doubleword |
| physTargetMode | input | 1 | 1 targets are physical addresses, 0 processor numbers |
| devTableEn | input | 1 | Device table is configured |
| collTableEn | input | 1 | Collection table is configured |
| maxDevId | input | 32 | Largest legal device number |
| maxCollId | input | 16 | Largest legal collection number |
| numProcs | input | 16 | Largest legal processor-number target |
| idBitsLimit | input | 5 | Largest legal width field |
| wrReq | output | 1 | One-cycle table-write request |
| wrTable | output | 1 | Table selected for the write |
| wrId | output | 32 | Row index of the write |
| wrEntry | output | 64 | Entry value to write |
| errFlag | output | 1 | One-cycle pulse for a rejected command |

## Verification
The bench uses the default field layout, which has a 5-bit width field, a 44-bit address and a 16-bit processor number. It sets the limits to small values: maxDevId 0xFFF, maxCollId 0xFF, numProcs 8 and idBitsLimit 15. With limits this small, random device and collection numbers land on, just below and just above each bound often. Random upper bits in every doubleword test that masking is correct. Both target modes and both table enables are toggled per command, so the target check, which applies in one mode only, and the table gating are exercised back to back.

// File: rtl/mapcmd_pkg.sv
package mapcmd_pkg;
  typedef enum logic {
    KIND_DEV  = 1'b0,
    KIND_COLL = 1'b1
  } cmdKind_e;

  // Decoded range checks from datapath to control
  typedef struct packed {
    logic mapValid;
    logic devIdHigh;
    logic sizeHigh;
    logic collIdHigh;
    logic targetHigh;
  } fieldFlags_t;

  // Control strobes into the datapath
  typedef struct packed {
    logic load;
    logic zeroEntry;
  } ctrlStrobe_t;
endpackage

// File: rtl/mapcmd_datapath.sv
module mapcmd_datapath
  import mapcmd_pkg::*;
#(
  parameter int DW_W       = 64,
  parameter int ID_W       = 32,
  parameter int DEVID_LSB  = 32,
  parameter int CID_W      = 16,
  parameter int SIZE_W     = 5,
  parameter int ADDR_LSB   = 8,
  parameter int ADDR_W     = 44,
  parameter int TGT_LSB    = 16,
  parameter int PHYS_TGT_W = 32,
  parameter int PROC_W     = 16,
  parameter int VALID_BIT  = 63
) (
  input  logic              clk,
  input  logic              rstN,
  input  cmdKind_e          cmdKind,
  input  logic [DW_W-1:0]   cmdDw0,
  input  logic [DW_W-1:0]   cmdDw1,
  input  logic [DW_W-1:0]   cmdDw2,
  input  logic              physTargetMode,
  input  logic [ID_W-1:0]   maxDevId,
  input  logic [CID_W-1:0]  maxCollId,
  input  logic [PROC_W-1:0] numProcs,
  input  logic [SIZE_W-1:0] idBitsLimit,
  input  ctrlStrobe_t       strobe,
  output fieldFlags_t       flags,
  output logic              wrTable,
  output logic [ID_W-1:0]   wrId,
  output logic [DW_W-1:0]   wrEntry
);
  localparam int DEV_ADDR_POS = 1 + SIZE_W;
  localparam int COLL_TGT_POS = 1;

  logic [ID_W-1:0]       devId;
  logic [SIZE_W-1:0]     sizeField;
  logic [ADDR_W-1:0]     ittAddr;
  logic [CID_W-1:0]      collId;
  logic [PROC_W-1:0]     procTarget;
  logic [PHYS_TGT_W-1:0] physTarget;
  logic [PHYS_TGT_W-1:0] targetField;
  logic [DW_W-1:0]       devEntry;
  logic [DW_W-1:0]       collEntry;
  logic [DW_W-1:0]       builtEntry;
  logic [ID_W-1:0]       builtId;
  logic                  unusedDw;

  assign unusedDw = ^{cmdDw0, cmdDw1, cmdDw2};

  // Field extraction
  assign devId      = cmdDw0[DEVID_LSB +: ID_W];
  assign sizeField  = cmdDw1[SIZE_W-1:0];
  assign ittAddr    = cmdDw2[ADDR_LSB +: ADDR_W];
  assign collId     = cmdDw2[CID_W-1:0];
  assign procTarget = cmdDw2[TGT_LSB +: PROC_W];
  assign physTarget = cmdDw2[TGT_LSB +: PHYS_TGT_W];

  always_comb begin
    if (physTargetMode) targetField = physTarget;
    else                targetField = PHYS_TGT_W'(procTarget);
  end

  // Limit comparisons; processor check only in processor-number mode
  always_comb begin
    flags.mapValid   = cmdDw2[VALID_BIT];
    flags.devIdHigh  = devId > maxDevId;
    flags.sizeHigh   = sizeField > idBitsLimit;
    flags.collIdHigh = collId > maxCollId;
    flags.targetHigh = !physTargetMode && (procTarget > numProcs);
  end

  // Two entry encodings
  always_comb begin
    devEntry = '0;
    devEntry[0] = 1'b1;
    devEntry[DEV_ADDR_POS-1:1] = sizeField;
    devEntry[DEV_ADDR_POS +: ADDR_W] = ittAddr;
  end

  always_comb begin
    collEntry = '0;
    collEntry[0] = 1'b1;
    collEntry[COLL_TGT_POS +: PHYS_TGT_W] = targetField;
  end

  always_comb begin
    if (strobe.zeroEntry)        builtEntry = '0;
    else if (cmdKind == KIND_DEV) builtEntry = devEntry;
    else                          builtEntry = collEntry;
    builtId = (cmdKind == KIND_DEV) ? devId : ID_W'(collId);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wrTable <= 1'b0;
      wrId    <= '0;
      wrEntry <= '0;
    end else if (strobe.load) begin
      wrTable <= (cmdKind == KIND_COLL);
      wrId    <= builtId;
      wrEntry <= builtEntry;
    end
  end
endmodule

// File: rtl/mapcmd_control.sv
module mapcmd_control
  import mapcmd_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        cmdValid,
  input  cmdKind_e    cmdKind,
  input  fieldFlags_t flags,
  input  logic        devTableEn,
  input  logic        collTableEn,
  output ctrlStrobe_t strobe,
  output logic        wrReq,
  output logic        errFlag
);
  logic tableOn;
  logic fieldBad;
  logic reject;

  always_comb begin
    if (cmdKind == KIND_DEV) begin
      tableOn  = devTableEn;
      fieldBad = flags.devIdHigh || flags.sizeHigh;
    end else begin
      tableOn  = collTableEn;
      fieldBad = flags.collIdHigh || flags.targetHigh;
    end
    reject           = flags.mapValid && fieldBad;
    strobe.load      = cmdValid && tableOn && !reject;
    strobe.zeroEntry = !flags.mapValid;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wrReq   <= 1'b0;
      errFlag <= 1'b0;
    end else begin
      wrReq   <= strobe.load;
      errFlag <= cmdValid && reject;
    end
  end
endmodule

// File: rtl/mapcmd_builder.sv
module mapcmd_builder
  import mapcmd_pkg::*;
#(
  parameter int DW_W       = 64,
  parameter int ID_W       = 32,
  parameter int DEVID_LSB  = 32,
  parameter int CID_W      = 16,
  parameter int SIZE_W     = 5,
  parameter int ADDR_LSB   = 8,
  parameter int ADDR_W     = 44,
  parameter int TGT_LSB    = 16,
  parameter int PHYS_TGT_W = 32,
  parameter int PROC_W     = 16,
  parameter int VALID_BIT  = 63
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cmdValid,
  input  logic              cmdKind,
  input  logic [DW_W-1:0]   cmdDw0,
  input  logic [DW_W-1:0]   cmdDw1,
  input  logic [DW_W-1:0]   cmdDw2,
  input  logic              physTargetMode,
  input  logic              devTableEn,
  input  logic              collTableEn,
  input  logic [ID_W-1:0]   maxDevId,
  input  logic [CID_W-1:0]  maxCollId,
  input  logic [PROC_W-1:0] numProcs,
  input  logic [SIZE_W-1:0] idBitsLimit,
  output logic              wrReq,
  output logic              wrTable,
  output logic [ID_W-1:0]   wrId,
  output logic [DW_W-1:0]   wrEntry,
  output logic              errFlag
);
  cmdKind_e    kindSel;
  fieldFlags_t flags;
  ctrlStrobe_t strobe;

  assign kindSel = cmdKind_e'(cmdKind);

  mapcmd_datapath #(
    .DW_W(DW_W), .ID_W(ID_W), .DEVID_LSB(DEVID_LSB), .CID_W(CID_W),
    .SIZE_W(SIZE_W), .ADDR_LSB(ADDR_LSB), .ADDR_W(ADDR_W),
    .TGT_LSB(TGT_LSB), .PHYS_TGT_W(PHYS_TGT_W), .PROC_W(PROC_W),
    .VALID_BIT(VALID_BIT)
  ) uData (
    .clk(clk), .rstN(rstN), .cmdKind(kindSel),
    .cmdDw0(cmdDw0), .cmdDw1(cmdDw1), .cmdDw2(cmdDw2),
    .physTargetMode(physTargetMode), .maxDevId(maxDevId),
    .maxCollId(maxCollId), .numProcs(numProcs), .idBitsLimit(idBitsLimit),
    .strobe(strobe), .flags(flags),
    .wrTable(wrTable), .wrId(wrId), .wrEntry(wrEntry)
  );

  mapcmd_control uCtrl (
    .clk(clk), .rstN(rstN), .cmdValid(cmdValid), .cmdKind(kindSel),
    .flags(flags), .devTableEn(devTableEn), .collTableEn(collTableEn),
    .strobe(strobe), .wrReq(wrReq), .errFlag(errFlag)
  );
endmodule

// File: rtl/mapcmd_checker.sv
module mapcmd_checker #(
  parameter int DW_W   = 64,
  parameter int SIZE_W = 5,
  parameter int ADDR_W = 44,
  parameter int PROC_W = 16
) (
  input logic            clk,
  input logic            rstN,
  input logic            cmdValid,
  input logic            physTargetMode,
  input logic            devTableEn,
  input logic            collTableEn,
  input logic            wrReq,
  input logic            wrTable,
  input logic [DW_W-1:0] wrEntry,
  input logic            errFlag
);
  localparam int DEV_TOP  = 1 + SIZE_W + ADDR_W;
  localparam int PROC_TOP = 1 + PROC_W;

  a_r6_r7_err_blocks_write: assert property (@(posedge clk) disable iff (!rstN)
    !(wrReq && errFlag));

  a_r10_pulse_needs_cmd: assert property (@(posedge clk) disable iff (!rstN)
    (wrReq || errFlag) |-> $past(cmdValid));

  a_r8_unmap_all_zero: assert property (@(posedge clk) disable iff (!rstN)
    (wrReq && !wrEntry[0]) |-> (wrEntry == '0));

  a_r9_dev_table_gate: assert property (@(posedge clk) disable iff (!rstN)
    (wrReq && !wrTable) |-> $past(devTableEn));

  a_r9_coll_table_gate: assert property (@(posedge clk) disable iff (!rstN)
    (wrReq && wrTable) |-> $past(collTableEn));

  a_r3_dev_upper_clear: assert property (@(posedge clk) disable iff (!rstN)
    (wrReq && !wrTable) |-> ((wrEntry >> DEV_TOP) == '0));

  a_r4_proc_target_narrow: assert property (@(posedge clk) disable iff (!rstN)
    (wrReq && wrTable && !$past(physTargetMode)) |-> ((wrEntry >> PROC_TOP) == '0));
endmodule

bind mapcmd_builder mapcmd_checker #(
  .DW_W(DW_W), .SIZE_W(SIZE_W), .ADDR_W(ADDR_W), .PROC_W(PROC_W)
) uChk (
  .clk(clk), .rstN(rstN), .cmdValid(cmdValid),
  .physTargetMode(physTargetMode), .devTableEn(devTableEn),
  .collTableEn(collTableEn), .wrReq(wrReq), .wrTable(wrTable),
  .wrEntry(wrEntry), .errFlag(errFlag)
);

// File: tb/sim_mapcmd_builder.sv
`timescale 1ns/1ps
module sim_mapcmd_builder;
  localparam logic [31:0] MAX_DEV = 32'h0000_0FFF;
  localparam logic [15:0] MAX_COLL = 16'h00FF;
  localparam logic [15:0] NPROCS = 16'd8;
  localparam logic [4:0]  IDB = 5'd15;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic cmdValid = 1'b0;
  logic cmdKind = 1'b0;
  logic [63:0] cmdDw0 = '0, cmdDw1 = '0, cmdDw2 = '0;
  logic physTargetMode = 1'b0, devTableEn = 1'b1, collTableEn = 1'b1;
  logic wrReq, wrTable, errFlag;
  logic [31:0] wrId;
  logic [63:0] wrEntry;

  always #2 clk = ~clk;

  mapcmd_builder u0 (
    .clk(clk), .rstN(rstN), .cmdValid(cmdValid), .cmdKind(cmdKind),
    .cmdDw0(cmdDw0), .cmdDw1(cmdDw1), .cmdDw2(cmdDw2),
    .physTargetMode(physTargetMode), .devTableEn(devTableEn),
    .collTableEn(collTableEn), .maxDevId(MAX_DEV), .maxCollId(MAX_COLL),
    .numProcs(NPROCS), .idBitsLimit(IDB),
    .wrReq(wrReq), .wrTable(wrTable), .wrId(wrId), .wrEntry(wrEntry),
    .errFlag(errFlag)
  );

  typedef struct packed {
    logic        wr;
    logic        err;
    logic        tbl;
    logic [31:0] id;
    logic [63:0] entry;
  } exp_t;

  int nCmp = 0;
  int nBad = 0;
  bit done = 1'b0;

  task automatic check(string req, logic [63:0] act, logic [63:0] exp);
    nCmp++;
    if (act !== exp) begin
      nBad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic exp_t model(logic kind, logic [63:0] d0, logic [63:0] d1,
                                 logic [63:0] d2, logic phys, logic den, logic cen);
    exp_t e;
    logic v, bad, en;
    v = d2[63];
    e = '0;
    if (!kind) begin
      e.id = d0[63:32];
      bad = v && ((d0[63:32] > MAX_DEV) || (d1[4:0] > IDB));
      en = den;
      e.entry = v ? {14'b0, d2[51:8], d1[4:0], 1'b1} : 64'd0;
    end else begin
      e.id = {16'b0, d2[15:0]};
      bad = v && ((d2[15:0] > MAX_COLL) || (!phys && (d2[31:16] > NPROCS)));
      en = cen;
      e.entry = !v ? 64'd0 :
                phys ? {31'b0, d2[47:16], 1'b1} : {47'b0, d2[31:16], 1'b1};
    end
    e.tbl = kind;
    e.err = bad;
    e.wr = en && !bad;
    return e;
  endfunction

  function automatic string tagFor(logic kind, logic [63:0] d2, exp_t e, logic en);
    if (e.err) return kind ? (en ? "R7" : "R7 R9") : (en ? "R6" : "R6 R9");
    if (!en) return "R9";
    if (!d2[63]) return "R8 R11";
    return kind ? "R4 R5 R11" : "R2 R3 R11";
  endfunction

  // Present one command; check its result one cycle later
  task automatic apply(logic kind, logic [63:0] d0, logic [63:0] d1,
                       logic [63:0] d2, logic phys, logic den, logic cen);
    exp_t e;
    string t;
    cmdValid = 1'b1; cmdKind = kind;
    cmdDw0 = d0; cmdDw1 = d1; cmdDw2 = d2;
    physTargetMode = phys; devTableEn = den; collTableEn = cen;
    e = model(kind, d0, d1, d2, phys, den, cen);
    t = tagFor(kind, d2, e, kind ? cen : den);
    @(posedge clk);
    @(negedge clk);
    check({t, " R10 wrReq"}, 64'(wrReq), 64'(e.wr));
    check({t, " errFlag"}, 64'(errFlag), 64'(e.err));
    if (e.wr) begin
      check({t, " wrTable"}, 64'(wrTable), 64'(e.tbl));
      check({t, " wrId"}, 64'(wrId), 64'(e.id));
      check({t, " wrEntry"}, wrEntry, e.entry);
    end
  endtask

  task automatic idle();
    cmdValid = 1'b0;
    cmdDw2 = {1'b1, 63'h7FFF_FFFF_FFFF_FFFF};
    @(posedge clk);
    @(negedge clk);
    check("R10 idle wrReq", 64'(wrReq), 64'd0);
    check("R10 idle errFlag", 64'(errFlag), 64'd0);
  endtask

  function automatic logic [63:0] rnd64();
    return {$urandom, $urandom};
  endfunction

  initial begin
    void'($urandom(32'd4711));
    repeat (3) @(negedge clk);
    check("R1 wrReq", 64'(wrReq), 64'd0);
    check("R1 errFlag", 64'(errFlag), 64'd0);
    check("R1 wrEntry", wrEntry, 64'd0);
    check("R1 wrId", 64'(wrId), 64'd0);
    check("R1 wrTable", 64'(wrTable), 64'd0);
    rstN = 1'b1;
    @(negedge clk);
    check("R1 after release", 64'({wrReq, errFlag}), 64'd0);

    // Directed device corners (R6 boundaries)
    apply(1'b0, {MAX_DEV, 32'hDEAD_BEEF}, {59'h1, IDB}, {1'b1, 11'h0, 44'h123_4567_89AB, 8'hFF}, 1'b0, 1'b1, 1'b1);
    apply(1'b0, {MAX_DEV + 32'd1, 32'h0}, 64'd3, {1'b1, 63'h100}, 1'b0, 1'b1, 1'b1);
    apply(1'b0, {32'd5, 32'h0}, {59'h0, IDB + 5'd1}, {1'b1, 63'h100}, 1'b0, 1'b1, 1'b1);
    // Unmap with out-of-range fields (R8)
    apply(1'b0, {32'hFFFF_FFFF, 32'h0}, 64'h1F, {1'b0, 63'h7FFF_FFFF_FFFF_FFFF}, 1'b0, 1'b1, 1'b1);
    // Table disabled (R9), valid and invalid fields
    apply(1'b0, {32'd7, 32'h0}, 64'd2, {1'b1, 63'h500}, 1'b0, 1'b0, 1'b1);
    apply(1'b0, {32'hFFFF_0000, 32'h0}, 64'd2, {1'b1, 63'h500}, 1'b0, 1'b0, 1'b1);
    idle();
    // Collection corners (R7, R4)
    apply(1'b1, rnd64(), rnd64(), {1'b1, 15'h0, 16'hABCD, NPROCS, MAX_COLL}, 1'b0, 1'b1, 1'b1);
    apply(1'b1, rnd64(), rnd64(), {1'b1, 15'h0, 16'h0, NPROCS + 16'd1, 16'd3}, 1'b0, 1'b1, 1'b1);
    apply(1'b1, rnd64(), rnd64(), {1'b1, 15'h0, 16'hFFFF, 16'hFFFF, 16'd3}, 1'b1, 1'b1, 1'b1);
    apply(1'b1, rnd64(), rnd64(), {1'b1, 15'h0, 16'h0, 16'd1, MAX_COLL + 16'd1}, 1'b1, 1'b1, 1'b1);
    apply(1'b1, rnd64(), rnd64(), {1'b0, 15'h0, 16'hFFFF, 16'hFFFF, 16'hFFFF}, 1'b0, 1'b1, 1'b1);
    apply(1'b1, rnd64(), rnd64(), {1'b1, 15'h0, 16'h0, 16'd2, 16'd4}, 1'b0, 1'b1, 1'b0);
    idle();

    // Constrained random, back to back with occasional idles
    for (int i = 0; i < 3000; i++) begin
      logic [63:0] d0, d1, d2;
      logic kind, phys, den, cen;
      d0 = rnd64(); d1 = rnd64(); d2 = rnd64();
      kind = $urandom % 2;
      phys = $urandom % 2;
      den = ($urandom % 8) != 0;
      cen = ($urandom % 8) != 0;
      d2[63] = ($urandom % 4) != 0;
      d0[63:32] = $urandom % 32'h1400;
      d1[4:0] = 5'($urandom % 20);
      d2[15:0] = 16'($urandom % 32'h140);
      d2[31:16] = 16'($urandom % 12);
      apply(kind, d0, d1, d2, phys, den, cen);
      if (($urandom % 16) == 0) idle();
    end
    idle();
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nCmp, nBad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      nBad++;
      $display("FAIL watchdog: actual hung expected done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", nCmp, nBad);
      $finish;
    end
  end
endmodule